// File: doc/BRIEF.md
# Dynamic-Resolution Three-Channel PWM Driver

This block generates three LED PWM waveforms and two regulator-enable levels from a single update request. Two of the waveforms come from one shared up/down (phase-correct) counter whose turn-around value, the top, is programmable at run time. Raising the top lengthens the period and gives finer duty steps at low brightness. The third waveform comes from a separate phase-correct counter with a fixed 8-bit range. The counters run at the clock rate with no prescaler, so the shared period is 2 x top clock cycles and the fixed period is 510 cycles.

A host presents two duties for the shared counter, one duty for the fixed counter and a new top value through a valid/ready handshake. The block decides how to apply each request. A request with every duty zero switches everything off at once. A request that turns the light on from off restarts the shared counter at phase zero. A request made while the light is already on changes the duties at the next counter bottom. In that case the new top is held back until the counter is at least 32 below it, so the counter never lands above a shrunken top.

Top module: `dynres_pwm_driver`

## Requirements
- R1: After reset all three PWM outputs and both enables are low, `req_ready` is 1 and `busy` is 0.
- R2: A shared channel with duty d, where 1 <= d < top, is high for exactly 2d-1 cycles in every 2 x top cycle period. With d = 0 it stays low. Both shared channels use the same period.
- R3: A shared channel whose duty is at or above the current top stays high.
- R4: The fixed channel is high for 2d-1 cycles in every 510-cycle period. With d = 255 it stays high, and with d = 0 it stays low.
- R5: On every accepted request, `en_a` becomes 1 exactly when the first shared duty is nonzero, and `en_b` becomes 1 exactly when the second shared duty is nonzero.
- R6: An accepted request whose three duties are all zero clears every compare value at once. It also drives all outputs and enables low, sets the top to 255 and forces the shared counter to 0.
- R7: An accepted request that turns the block on from off forces the shared counter to 0 and loads the new duties and top immediately. A shared duty d < top then gives exactly d high cycles followed by a low cycle, starting the cycle after acceptance.
- R8: A request accepted while the block is on writes its top only on a clock edge where the shared counter is at or below new top - 32. Until that write, `busy` is 1 and `req_ready` is 0.
- R9: A request accepted while the block is on changes the compare values only when the counter concerned reaches 0. The remainder of the current period keeps the old duty.
- R10: A requested top below 32 is raised to 32.
- R11: A request is taken only on a clock edge where both `req_valid` and `req_ready` are 1. A request held while `req_ready` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both counters step once per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_duty_a | input | 8 | Duty for shared channel A |
| req_duty_b | input | 8 | Duty for shared channel B |
| req_duty_c | input | 8 | Duty for the fixed-range channel C |
| req_top | input | 16 | Turn-around value requested for the shared counter |
| busy | output | 1 | A deferred top write is pending |
| pwm_a | output | 1 | Shared channel A waveform |
| pwm_b | output | 1 | Shared channel B waveform |
| pwm_c | output | 1 | Fixed-range channel C waveform |
| en_a | output | 1 | Regulator enable for channel A |
| en_b | output | 1 | Regulator enable for channel B |

## Verification
The hardest case to reach is a top change made while the light is on with the shared counter high in a long period, so that the write has to wait across a turn-around. The bench reaches it by first turning the light on from off, which forces the counter to a known phase. It then counts cycles up to a chosen counter value before sending the second request. From that known phase it predicts the exact number of busy cycles. The same wait window is used to hold a competing request against a low ready, and a second phase-locked scenario lands a duty change mid-period to show the old compare value persists until the bottom.

// File: rtl/dynres_pwm_pkg.sv
// Package: shared types and defaults for the dynamic-resolution PWM driver.
// Assumes: nothing beyond IEEE 1800-2017.
package dynres_pwm_pkg;

    localparam int DEF_DUTY_W      = 8;
    localparam int DEF_TOP_W       = 16;
    localparam int DEF_SYNC_MARGIN = 32;
    localparam int DEF_TOP_RESET   = 255;
    localparam int DEF_FIXED_TOP   = 255;

    // Update sequencer states
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_t;

endpackage

// File: rtl/updown_ctr.sv
// Module: phase-correct up/down counter. It counts 0 -> top -> 0 and yields
// a period of 2*top cycles.
// Assumes: top never drops below the current count while counting (the
// caller guarantees this through its update rules); clr restarts at 0 upward.
module updown_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         at_bottom
);

    logic [W-1:0] cnt_q;
    logic         up_q;

    // Step the count and flip direction at the two turn-around points
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (clr) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (up_q) begin
            if (cnt_q >= top) begin
                up_q  <= 1'b0;
                cnt_q <= top - W'(1);
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end else begin
            if (cnt_q == '0) begin
                up_q  <= 1'b1;
                cnt_q <= W'(1);
            end else begin
                cnt_q <= cnt_q - W'(1);
            end
        end
    end

    assign cnt       = cnt_q;
    assign at_bottom = (cnt_q == '0);

    // R8
    cnt_within_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= top)
        else $error("counter above top");

endmodule

// File: rtl/pwm_chan.sv
// Module: one PWM compare channel. It holds the active compare value and
// drives the output high while the counter is below it, or always when the
// compare value reaches the top.
// Assumes: W >= DW; load_now takes priority over the bottom-of-period latch.
module pwm_chan #(
    parameter int W  = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  cnt,
    input  logic [W-1:0]  top,
    input  logic          at_bottom,
    input  logic          load_now,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] shadow,
    output logic          pwm_o
);

    logic [DW-1:0] cmp_q;
    logic [W-1:0]  cmp_ext;

    // Take a new compare value immediately or at the counter bottom
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (load_now) begin
            cmp_q <= load_val;
        end else if (at_bottom) begin
            cmp_q <= shadow;
        end
    end

    // Compare against the running counter in normal polarity
    always_comb begin
        cmp_ext = W'(cmp_q);
        pwm_o   = (cnt < cmp_ext) || ((cmp_ext >= top) && (cmp_ext != '0));
    end

endmodule

// File: rtl/update_seq.sv
// Module: update sequencer. It accepts requests, drives the enables, selects
// the off / first-on / already-on path, and defers top writes until the
// shared counter is at least SYNC_MARGIN below the new top.
// Assumes: cnt_s is the shared counter value; SYNC_MARGIN is the minimum top.
module update_seq
    import dynres_pwm_pkg::*;
#(
    parameter int DW          = DEF_DUTY_W,
    parameter int TW          = DEF_TOP_W,
    parameter int SYNC_MARGIN = DEF_SYNC_MARGIN,
    parameter int TOP_RESET   = DEF_TOP_RESET
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [DW-1:0] duty_a,
    input  logic [DW-1:0] duty_b,
    input  logic [DW-1:0] duty_c,
    input  logic [TW-1:0] req_top,
    input  logic [TW-1:0] cnt_s,
    output logic          busy,
    output logic          en_a,
    output logic          en_b,
    output logic [DW-1:0] sh_a,
    output logic [DW-1:0] sh_b,
    output logic [DW-1:0] sh_c,
    output logic          load_now,
    output logic          clr_s,
    output logic [TW-1:0] top_o
);

    localparam logic [TW-1:0] MARGIN  = TW'(SYNC_MARGIN);
    localparam logic [TW-1:0] TOP_RST = TW'(TOP_RESET);

    seq_state_t    state_q;
    logic [TW-1:0] top_q, top_pend_q, top_clamped;
    logic          on_q, en_a_q, en_b_q;
    logic [DW-1:0] sh_a_q, sh_b_q, sh_c_q;
    logic          fire, now_on, sync_ok;

    // Decode the request and the phase-sync condition
    always_comb begin
        fire        = req_valid && (state_q == SEQ_IDLE);
        now_on      = (duty_a != '0) || (duty_b != '0) || (duty_c != '0);
        top_clamped = (req_top < MARGIN) ? MARGIN : req_top;
        sync_ok     = (cnt_s <= top_pend_q - MARGIN);
        load_now    = fire && (!now_on || !on_q);
        clr_s       = load_now;
    end

    // Sequence the update and hold the applied state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            top_q      <= TOP_RST;
            top_pend_q <= TOP_RST;
            on_q       <= 1'b0;
            en_a_q     <= 1'b0;
            en_b_q     <= 1'b0;
            sh_a_q     <= '0;
            sh_b_q     <= '0;
            sh_c_q     <= '0;
        end else if (fire) begin
            on_q   <= now_on;
            en_a_q <= (duty_a != '0);
            en_b_q <= (duty_b != '0);
            sh_a_q <= duty_a;
            sh_b_q <= duty_b;
            sh_c_q <= duty_c;
            if (!now_on) begin
                top_q <= TOP_RST;
            end else if (!on_q) begin
                top_q <= top_clamped;
            end else begin
                top_pend_q <= top_clamped;
                state_q    <= SEQ_WAIT;
            end
        end else if (state_q == SEQ_WAIT && sync_ok) begin
            top_q   <= top_pend_q;
            state_q <= SEQ_IDLE;
        end
    end

    assign req_ready = (state_q == SEQ_IDLE);
    assign busy      = (state_q == SEQ_WAIT);
    assign en_a      = en_a_q;
    assign en_b      = en_b_q;
    assign sh_a      = sh_a_q;
    assign sh_b      = sh_b_q;
    assign sh_c      = sh_c_q;
    assign top_o     = top_q;

    // R10
    top_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_q >= MARGIN)
        else $error("top below minimum");

    // R6
    off_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !now_on) |=> (top_q == TOP_RST && cnt_s == '0 && !en_a_q && !en_b_q))
        else $error("off request not applied");

    // R5
    enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (en_a_q == ($past(duty_a) != '0)) && (en_b_q == ($past(duty_b) != '0)))
        else $error("enable does not follow duty");

    // R7
    phase_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && now_on && !on_q) |=> (cnt_s == '0))
        else $error("counter not restarted on first turn-on");

    // R8
    sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_q && $past(on_q) && !$stable(top_q))
            |-> ({1'b0, $past(cnt_s)} + {1'b0, MARGIN} <= {1'b0, top_q}))
        else $error("top written outside sync window");

endmodule

// File: rtl/dynres_pwm_driver.sv
// Module: top of the dynamic-resolution PWM driver. It ties the sequencer,
// the shared and fixed counters and three compare channels together.
// Assumes: FIXED_TOP + 1 is a power of two; DUTY_W <= both counter widths.
module dynres_pwm_driver
    import dynres_pwm_pkg::*;
#(
    parameter int DUTY_W      = DEF_DUTY_W,
    parameter int TOP_W       = DEF_TOP_W,
    parameter int SYNC_MARGIN = DEF_SYNC_MARGIN,
    parameter int TOP_RESET   = DEF_TOP_RESET,
    parameter int FIXED_TOP   = DEF_FIXED_TOP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DUTY_W-1:0] req_duty_a,
    input  logic [DUTY_W-1:0] req_duty_b,
    input  logic [DUTY_W-1:0] req_duty_c,
    input  logic [TOP_W-1:0]  req_top,
    output logic              busy,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic              pwm_c,
    output logic              en_a,
    output logic              en_b
);

    localparam int N_SHARED = 2;
    localparam int FIX_W    = $clog2(FIXED_TOP + 1);

    logic [TOP_W-1:0]  cnt_s, top_s;
    logic [FIX_W-1:0]  cnt_f;
    logic              bot_s, bot_f, load_now, clr_s;
    logic [DUTY_W-1:0] sh_a, sh_b, sh_c;
    logic [DUTY_W-1:0] load_v  [N_SHARED];
    logic [DUTY_W-1:0] shad_v  [N_SHARED];
    logic              pwm_v   [N_SHARED];

    update_seq #(
        .DW(DUTY_W), .TW(TOP_W), .SYNC_MARGIN(SYNC_MARGIN), .TOP_RESET(TOP_RESET)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .duty_a(req_duty_a), .duty_b(req_duty_b), .duty_c(req_duty_c),
        .req_top(req_top), .cnt_s(cnt_s), .busy(busy), .en_a(en_a), .en_b(en_b),
        .sh_a(sh_a), .sh_b(sh_b), .sh_c(sh_c), .load_now(load_now),
        .clr_s(clr_s), .top_o(top_s)
    );

    updown_ctr #(.W(TOP_W)) u_ctr_shared (
        .clk(clk), .rst_n(rst_n), .clr(clr_s), .top(top_s),
        .cnt(cnt_s), .at_bottom(bot_s)
    );

    updown_ctr #(.W(FIX_W)) u_ctr_fixed (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .top(FIX_W'(FIXED_TOP)),
        .cnt(cnt_f), .at_bottom(bot_f)
    );

    // Route request and shadow duties into the shared-channel array
    always_comb begin
        load_v[0] = req_duty_a;
        load_v[1] = req_duty_b;
        shad_v[0] = sh_a;
        shad_v[1] = sh_b;
    end

    for (genvar g = 0; g < N_SHARED; g++) begin : g_shared
        pwm_chan #(.W(TOP_W), .DW(DUTY_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .cnt(cnt_s), .top(top_s),
            .at_bottom(bot_s), .load_now(load_now), .load_val(load_v[g]),
            .shadow(shad_v[g]), .pwm_o(pwm_v[g])
        );
    end

    pwm_chan #(.W(FIX_W), .DW(DUTY_W)) u_chan_fixed (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_f), .top(FIX_W'(FIXED_TOP)),
        .at_bottom(bot_f), .load_now(load_now), .load_val(req_duty_c),
        .shadow(sh_c), .pwm_o(pwm_c)
    );

    assign pwm_a = pwm_v[0];
    assign pwm_b = pwm_v[1];

endmodule

// File: tb/dynres_pwm_driver_test.sv
`timescale 1ns/1ps
module dynres_pwm_driver_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [7:0]  req_duty_a, req_duty_b, req_duty_c;
    logic [15:0] req_top;
    logic        busy, pwm_a, pwm_b, pwm_c, en_a, en_b;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dynres_pwm_driver uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_duty_a(req_duty_a), .req_duty_b(req_duty_b), .req_duty_c(req_duty_c),
        .req_top(req_top), .busy(busy), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .pwm_c(pwm_c), .en_a(en_a), .en_b(en_b)
    );

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Count high samples of one output over n falling edges (0=a, 1=b, 2=c)
    task automatic count_high(input int sel, input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            if ((sel == 0 && pwm_a) || (sel == 1 && pwm_b) || (sel == 2 && pwm_c))
                hits++;
            @(negedge clk);
        end
    endtask

    task automatic send(input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic [15:0] t);
        while (!req_ready) @(negedge clk);
        req_duty_a = a; req_duty_b = b; req_duty_c = c; req_top = t;
        req_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic settle(input int n);
        while (busy) @(negedge clk);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        int h;
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 enables", int'({en_a, en_b}), 0);
        count_high(0, 510, h); chk("R1 pwm_a idle", h, 0);
        count_high(1, 510, h); chk("R1 pwm_b idle", h, 0);
        count_high(2, 510, h); chk("R1 pwm_c idle", h, 0);
    endtask

    task automatic t_phase_start();
        int h;
        send(0, 0, 0, 255);
        send(64, 0, 0, 100);
        count_high(0, 64, h);
        chk("R7 first high run", h, 64);
        chk("R7 low after run", int'(pwm_a), 0);
        chk("R5 en_a on", int'(en_a), 1);
        chk("R5 en_b off", int'(en_b), 0);
    endtask

    task automatic t_shared();
        int h;
        send(30, 70, 0, 100);
        settle(400);
        count_high(0, 200, h); chk("R2 a top100 d30", h, 59);
        count_high(1, 200, h); chk("R2 b top100 d70", h, 139);
        chk("R5 en_b on", int'(en_b), 1);
        send(10, 0, 0, 40);
        settle(200);
        count_high(0, 80, h); chk("R2 a top40 d10", h, 19);
        count_high(1, 80, h); chk("R2 b zero duty", h, 0);
        chk("R5 en_b cleared", int'(en_b), 0);
    endtask

    task automatic t_full();
        int h;
        send(200, 150, 0, 150);
        settle(400);
        count_high(0, 300, h); chk("R3 duty above top", h, 300);
        count_high(1, 300, h); chk("R3 duty equal top", h, 300);
    endtask

    task automatic t_fixed();
        int h;
        send(1, 0, 100, 100);
        settle(600);
        count_high(2, 510, h); chk("R4 fixed d100", h, 199);
        send(1, 0, 255, 100);
        settle(600);
        count_high(2, 510, h); chk("R4 fixed d255", h, 510);
        send(1, 0, 0, 100);
        settle(600);
        count_high(2, 510, h); chk("R4 fixed d0", h, 0);
    endtask

    task automatic t_off();
        int h;
        send(50, 50, 50, 100);
        settle(600);
        send(0, 0, 0, 500);
        chk("R6 enables low", int'({en_a, en_b}), 0);
        chk("R6 ready", int'(req_ready), 1);
        count_high(0, 510, h); chk("R6 pwm_a off", h, 0);
        count_high(1, 510, h); chk("R6 pwm_b off", h, 0);
        count_high(2, 510, h); chk("R6 pwm_c off", h, 0);
    endtask

    task automatic t_min_top();
        int h;
        send(20, 0, 0, 10);
        count_high(0, 64, h); chk("R10 top 10 raised", h, 39);
        send(20, 0, 0, 0);
        settle(100);
        count_high(0, 64, h); chk("R10 top 0 raised", h, 39);
    endtask

    task automatic t_sync();
        int h, n;
        send(0, 0, 0, 255);
        send(10, 0, 0, 1000);
        repeat (899) @(negedge clk);
        send(10, 0, 0, 100);
        chk("R8 busy after accept", int'(busy), 1);
        chk("R8 ready low", int'(req_ready), 0);
        n = 0;
        req_duty_a = 200; req_duty_b = 77; req_duty_c = 0; req_top = 300;
        req_valid  = 1'b1;
        for (int i = 0; i < 5; i++) begin
            if (busy) n++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R11 held request ignored", int'(en_b), 0);
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk("R8 deferred cycles", n, 1033);
        chk("R11 en_b still off", int'(en_b), 0);
        repeat (300) @(negedge clk);
        count_high(0, 200, h); chk("R8 new top in use", h, 19);
    endtask

    task automatic t_latch();
        int h;
        send(0, 0, 0, 255);
        send(10, 0, 0, 100);
        repeat (50) @(negedge clk);
        send(90, 0, 0, 100);
        chk("R8 short wait busy", int'(busy), 1);
        count_high(0, 5, h); chk("R9 old duty kept mid-period", h, 0);
        chk("R8 short wait done", int'(req_ready), 1);
        repeat (300) @(negedge clk);
        count_high(0, 200, h); chk("R9 new duty after bottom", h, 179);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_duty_a = '0; req_duty_b = '0; req_duty_c = '0; req_top = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_phase_start();
        t_shared();
        t_full();
        t_fixed();
        t_off();
        t_min_top();
        t_sync();
        t_latch();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule